// File: doc/BRIEF.md
# Standby Power Sequencer

This block steps a small processor core through its power states: power-up, oscillator stabilization, reset, normal run, sleep and stop. Software enters a low-power state by writing the sleep or stop request bit. An interrupt ends sleep. An external interrupt or a reset ends stop. Every path that needs the oscillator to be stable, including leaving stop, waits on an internal timebase counter. The wait ends when that counter reaches `STAB_CYCLES`. The outputs drive the core reset, the CPU clock gate, the oscillator enable and the timebase start strobe, and report the current state.

The parameter `HAS_POR` selects one of two variants. With it set, releasing the supply-good input starts the stabilization wait on its own. With it clear, the block stays in power-up until the external reset pin is held long enough for the timebase to overflow. The same hold rule applies to an external reset in stop. A shorter pulse returns the block to the state it came from.

Top module: `pwr_seq`

## Requirements
- R1: While `pwr_up_n` is low, `state_o` is 0 (power-up), `core_rst` is 1 and both `osc_en` and `cpu_clk_en` are 0. The state codes are 0 power-up, 1 power stabilization, 2 reset, 3 run, 4 sleep, 5 stop, 6 wake stabilization and 7 reset hold.
- R2: With `HAS_POR`=1, once `pwr_up_n` rises, the block spends exactly `STAB_CYCLES` cycles in state 1 and then enters state 2.
- R3: In state 2, the block moves to run in the cycle after `ext_rst` and every bit of `int_rst` are low. It stays in state 2 while any of them is high.
- R4: In run, a high `ext_rst` or any high bit of `int_rst` moves the block to state 2 on the next cycle.
- R5: A one-cycle `slp_wr` pulse in run sets the sleep bit on the next edge and gives state 4 on the edge after that. In sleep, `cpu_clk_en` is 0 and `osc_en` is 1.
- R6: In sleep, `irq` or `ext_irq` returns the block to run on the next cycle.
- R7: A `stp_wr` pulse in run gives state 5 two edges later, with `cpu_clk_en` and `osc_en` both 0. In stop, `irq` alone has no effect.
- R8: In stop, `ext_irq` moves the block to state 6. It holds `core_rst` low there for exactly `STAB_CYCLES` cycles and then returns to run.
- R9: A high `ext_rst` in sleep moves the block to state 2 on the next cycle. With `HAS_POR`=1, the same applies in stop.
- R10: When `slp_wr` and `stp_wr` are written in the same run cycle, the block enters stop.
- R11: Both request bits clear when the block re-enters run, so it stays in run after a wake until a new write arrives.
- R12: With `HAS_POR`=0, power-up holds state 0 until `ext_rst` rises. An `ext_rst` in state 0 or 5 gives state 7. If `ext_rst` is held for `STAB_CYCLES` cycles, the block reaches state 2. If it is released earlier, the block returns to the state it came from.
- R13: `stab_start` is high only in the cycle where the block enters a counting state (1, 6 or 7), and the timebase reads zero on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_up_n | input | 1 | Supply-good, active low; low forces power-up |
| ext_rst | input | 1 | External reset pin, active high |
| int_rst | input | RST_SRC_N | Internal reset sources, active high |
| slp_wr | input | 1 | Write strobe setting the sleep request bit |
| stp_wr | input | 1 | Write strobe setting the stop request bit |
| irq | input | 1 | General interrupt request |
| ext_irq | input | 1 | External interrupt request |
| core_rst | output | 1 | Reset to the core |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| stab_start | output | 1 | Timebase start strobe |
| state_o | output | 3 | Current state code |

## Verification
The wake inputs are tried in sleep and in stop. This shows that sleep accepts either interrupt, while stop ignores `irq` and accepts only `ext_irq`. The stabilization length is measured on both paths that count: power-up and wake from stop. Reset is applied in run, sleep, stop and reset-hold, with both short and long pulses of `ext_rst` on a second instance built without power-on reset. This separates an incomplete reset hold from a completed one. A simultaneous write of both request bits shows the stop priority.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP   = 3'd0,
    ST_STAB_PU = 3'd1,
    ST_RESET   = 3'd2,
    ST_RUN     = 3'd3,
    ST_SLEEP   = 3'd4,
    ST_STOP    = 3'd5,
    ST_STAB_WK = 3'd6,
    ST_HOLD    = 3'd7
  } pwr_state_e;

  function automatic logic is_counting(input pwr_state_e s);
    return (s == ST_STAB_PU) || (s == ST_STAB_WK) || (s == ST_HOLD);
  endfunction

  function automatic logic tb_limit_hit(input int unsigned cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction
endpackage

// File: rtl/pwr_seq_timebase.sv
module pwr_seq_timebase #(
  parameter int unsigned STAB_CYCLES = 16,
  localparam int CW = $clog2(STAB_CYCLES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  output logic          ovf,
  output logic [CW-1:0] cnt
);
  import pwr_seq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign ovf = run && tb_limit_hit(32'(cnt), STAB_CYCLES);

  assert_start_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0));
endmodule

// File: rtl/pwr_seq_reqreg.sv
module pwr_seq_reqreg (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic clear,
  input  logic slp_wr,
  input  logic stp_wr,
  output logic slp_bit,
  output logic stp_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_bit <= 1'b0;
      stp_bit <= 1'b0;
    end else if (clear) begin
      slp_bit <= 1'b0;
      stp_bit <= 1'b0;
    end else if (accept) begin
      if (slp_wr) slp_bit <= 1'b1;
      if (stp_wr) stp_bit <= 1'b1;
    end
  end

  assert_both_written_stop_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !clear && slp_wr && stp_wr) |=> stp_bit);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm #(
  parameter bit          HAS_POR   = 1'b1,
  parameter int unsigned RST_SRC_N = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_rst,
  input  logic [RST_SRC_N-1:0]  int_rst,
  input  logic                  slp_bit,
  input  logic                  stp_bit,
  input  logic                  irq,
  input  logic                  ext_irq,
  input  logic                  tb_ovf,
  output pwr_seq_pkg::pwr_state_e state,
  output logic                  enter_run,
  output logic                  enter_count
);
  import pwr_seq_pkg::*;

  pwr_state_e nxt;
  logic       hold_from_stop, hold_from_stop_nxt;
  logic       any_rst;
  logic       hold_to_reset;

  assign any_rst = ext_rst || (|int_rst);

  always_comb begin
    nxt = state;
    hold_from_stop_nxt = hold_from_stop;
    unique case (state)
      ST_PWRUP: begin
        if (HAS_POR) nxt = ST_STAB_PU;
        else if (ext_rst) begin
          nxt = ST_HOLD;
          hold_from_stop_nxt = 1'b0;
        end
      end
      ST_STAB_PU: if (tb_ovf) nxt = ST_RESET;
      ST_RESET:   if (!any_rst) nxt = ST_RUN;
      ST_RUN: begin
        if (any_rst)      nxt = ST_RESET;
        else if (stp_bit) nxt = ST_STOP;
        else if (slp_bit) nxt = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (ext_rst)            nxt = ST_RESET;
        else if (irq || ext_irq) nxt = ST_RUN;
      end
      ST_STOP: begin
        if (ext_rst) begin
          if (HAS_POR) nxt = ST_RESET;
          else begin
            nxt = ST_HOLD;
            hold_from_stop_nxt = 1'b1;
          end
        end else if (ext_irq) nxt = ST_STAB_WK;
      end
      ST_STAB_WK: begin
        if (ext_rst)     nxt = ST_RESET;
        else if (tb_ovf) nxt = ST_RUN;
      end
      ST_HOLD: begin
        if (!ext_rst)    nxt = hold_from_stop ? ST_STOP : ST_PWRUP;
        else if (tb_ovf) nxt = ST_RESET;
      end
      default: nxt = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_PWRUP;
      hold_from_stop <= 1'b0;
    end else begin
      state          <= nxt;
      hold_from_stop <= hold_from_stop_nxt;
    end
  end

  assign enter_run     = (nxt == ST_RUN) && (state != ST_RUN);
  assign enter_count   = is_counting(nxt) && !is_counting(state);
  assign hold_to_reset = (state == ST_HOLD) && ext_rst && tb_ovf;

  assert_reset_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESET && !ext_rst && int_rst == '0) |=> state == ST_RUN);
  assert_run_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && (ext_rst || int_rst != '0)) |=> state == ST_RESET);
  assert_sleep_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && !ext_rst && (irq || ext_irq)) |=> state == ST_RUN);
  assert_stop_irq_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && !ext_rst && !ext_irq) |=> state == ST_STOP);
  assert_wake_wait_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STAB_WK && !ext_rst && !tb_ovf) |=> state == ST_STAB_WK);
  assert_sleep_ext_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && ext_rst) |=> state == ST_RESET);
  assert_short_hold_no_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !ext_rst) |=> state != ST_RESET);
  assert_hold_complete_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hold_to_reset |=> state == ST_RESET);
  assert_ovf_only_counting_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tb_ovf |-> is_counting(state));
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter bit          HAS_POR     = 1'b1,
  parameter int unsigned STAB_CYCLES = 16,
  parameter int unsigned RST_SRC_N   = 4
) (
  input  logic                 clk,
  input  logic                 pwr_up_n,
  input  logic                 ext_rst,
  input  logic [RST_SRC_N-1:0] int_rst,
  input  logic                 slp_wr,
  input  logic                 stp_wr,
  input  logic                 irq,
  input  logic                 ext_irq,
  output logic                 core_rst,
  output logic                 cpu_clk_en,
  output logic                 osc_en,
  output logic                 stab_start,
  output logic [2:0]           state_o
);
  import pwr_seq_pkg::*;
  localparam int CW = $clog2(STAB_CYCLES) + 1;

  pwr_state_e    state;
  logic          slp_bit, stp_bit;
  logic          tb_ovf, enter_run, enter_count;
  logic [CW-1:0] tb_cnt;

  pwr_seq_reqreg u_req (
    .clk(clk), .rst_n(pwr_up_n),
    .accept(state == ST_RUN), .clear(enter_run),
    .slp_wr(slp_wr), .stp_wr(stp_wr),
    .slp_bit(slp_bit), .stp_bit(stp_bit)
  );

  pwr_seq_timebase #(.STAB_CYCLES(STAB_CYCLES)) u_tb (
    .clk(clk), .rst_n(pwr_up_n),
    .start(enter_count), .run(is_counting(state)),
    .ovf(tb_ovf), .cnt(tb_cnt)
  );

  pwr_seq_fsm #(.HAS_POR(HAS_POR), .RST_SRC_N(RST_SRC_N)) u_fsm (
    .clk(clk), .rst_n(pwr_up_n),
    .ext_rst(ext_rst), .int_rst(int_rst),
    .slp_bit(slp_bit), .stp_bit(stp_bit),
    .irq(irq), .ext_irq(ext_irq), .tb_ovf(tb_ovf),
    .state(state), .enter_run(enter_run), .enter_count(enter_count)
  );

  assign state_o    = state;
  assign stab_start = enter_count;
  assign core_rst   = (state == ST_PWRUP) || (state == ST_STAB_PU) ||
                      (state == ST_RESET) || (state == ST_HOLD);
  assign cpu_clk_en = (state == ST_RUN) || (state == ST_RESET);
  assign osc_en     = (state != ST_STOP) && (state != ST_PWRUP);

  assert_stop_clock_off_R7: assert property (@(posedge clk) disable iff (!pwr_up_n)
    $rose(state == ST_STOP) |-> (!osc_en && !cpu_clk_en));
  assert_sleep_osc_kept_R5: assert property (@(posedge clk) disable iff (!pwr_up_n)
    (state == ST_SLEEP) |-> (osc_en && !cpu_clk_en));
endmodule

// File: tb/test_pwr_seq.sv
module test_pwr_seq;
  localparam int STAB = 8;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic pwr_up_n, ext_rst, slp_wr, stp_wr, irq, ext_irq;
  logic [3:0] int_rst;
  logic core_rst, cpu_clk_en, osc_en, stab_start;
  logic [2:0] state_o;

  logic n_pwr_up_n, n_ext_rst, n_stp_wr;
  logic n_core_rst, n_cpu_clk_en, n_osc_en, n_stab_start;
  logic [2:0] n_state;

  int checks = 0, failures = 0;
  bit done = 0;

  pwr_seq #(.HAS_POR(1'b1), .STAB_CYCLES(STAB), .RST_SRC_N(4)) i_pwr_seq (
    .clk(clk), .pwr_up_n(pwr_up_n), .ext_rst(ext_rst), .int_rst(int_rst),
    .slp_wr(slp_wr), .stp_wr(stp_wr), .irq(irq), .ext_irq(ext_irq),
    .core_rst(core_rst), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .stab_start(stab_start), .state_o(state_o));

  pwr_seq #(.HAS_POR(1'b0), .STAB_CYCLES(STAB), .RST_SRC_N(4)) i_pwr_seq_nopor (
    .clk(clk), .pwr_up_n(n_pwr_up_n), .ext_rst(n_ext_rst), .int_rst(4'b0),
    .slp_wr(1'b0), .stp_wr(n_stp_wr), .irq(1'b0), .ext_irq(1'b0),
    .core_rst(n_core_rst), .cpu_clk_en(n_cpu_clk_en), .osc_en(n_osc_en),
    .stab_start(n_stab_start), .state_o(n_state));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_main(input logic [2:0] st, output int n);
    n = 0;
    while (state_o == st && n < 100) begin step(); n++; end
  endtask

  task automatic count_np(input logic [2:0] st, output int n);
    n = 0;
    while (n_state == st && n < 100) begin step(); n++; end
  endtask

  task automatic t_powerup;
    int n;
    pwr_up_n = 0; n_pwr_up_n = 0;
    step(3);
    chk("R1 state", state_o, 0);
    chk("R1 core_rst", core_rst, 1);
    chk("R1 osc_en", osc_en, 0);
    chk("R1 cpu_clk_en", cpu_clk_en, 0);
    pwr_up_n = 1; n_pwr_up_n = 1;
    #1 chk("R13 start on power stab entry", stab_start, 1);
    step();
    chk("R2 enters power stab", state_o, 1);
    chk("R13 start one cycle", stab_start, 0);
    count_main(3'd1, n);
    chk("R2 power stab length", n, STAB);
    chk("R2 then reset state", state_o, 2);
    step();
    chk("R3 reset released to run", state_o, 3);
  endtask

  task automatic t_sleep;
    slp_wr = 1; step(); slp_wr = 0;
    chk("R5 not yet asleep", state_o, 3);
    step();
    chk("R5 sleep state", state_o, 4);
    chk("R5 cpu clock off", cpu_clk_en, 0);
    chk("R5 osc kept", osc_en, 1);
    step(3);
    chk("R6 stays asleep w/o irq", state_o, 4);
    irq = 1; step(); irq = 0;
    chk("R6 irq wakes sleep", state_o, 3);
    step(3);
    chk("R11 stays run after wake", state_o, 3);
    slp_wr = 1; step(); slp_wr = 0; step();
    ext_irq = 1; step(); ext_irq = 0;
    chk("R6 ext_irq wakes sleep", state_o, 3);
  endtask

  task automatic t_stop;
    int n;
    stp_wr = 1; step(); stp_wr = 0; step();
    chk("R7 stop state", state_o, 5);
    chk("R7 osc off", osc_en, 0);
    chk("R7 cpu clock off", cpu_clk_en, 0);
    irq = 1; step(2); irq = 0;
    chk("R7 irq ignored in stop", state_o, 5);
    ext_irq = 1;
    #1 chk("R13 start on wake", stab_start, 1);
    step(); ext_irq = 0;
    chk("R8 wake stab state", state_o, 6);
    chk("R8 core_rst low", core_rst, 0);
    count_main(3'd6, n);
    chk("R8 wake stab length", n, STAB);
    chk("R8 then run", state_o, 3);
    step(3);
    chk("R11 stays run after stop wake", state_o, 3);
  endtask

  task automatic t_both_and_resets;
    slp_wr = 1; stp_wr = 1; step(); slp_wr = 0; stp_wr = 0; step();
    chk("R10 stop wins", state_o, 5);
    ext_rst = 1; step();
    chk("R9 ext reset in stop", state_o, 2);
    step(2);
    chk("R3 held in reset", state_o, 2);
    chk("R3 core_rst in reset", core_rst, 1);
    ext_rst = 0; step();
    chk("R3 release to run", state_o, 3);
    slp_wr = 1; step(); slp_wr = 0; step();
    ext_rst = 1; step(); ext_rst = 0;
    chk("R9 ext reset in sleep", state_o, 2);
    step();
    chk("R3 run again", state_o, 3);
    int_rst = 4'b0100; step();
    chk("R4 internal reset in run", state_o, 2);
    step();
    chk("R3 held by internal source", state_o, 2);
    int_rst = 4'b0; step();
    chk("R3 run after internal", state_o, 3);
    ext_rst = 1; step(); ext_rst = 0;
    chk("R4 external reset in run", state_o, 2);
    step();
  endtask

  task automatic t_nopor;
    int n;
    step(4);
    chk("R12 powerup waits", n_state, 0);
    chk("R12 osc off in powerup", n_osc_en, 0);
    n_ext_rst = 1; step();
    chk("R12 hold state", n_state, 7);
    step(2); n_ext_rst = 0; step();
    chk("R12 short pulse back to powerup", n_state, 0);
    n_ext_rst = 1; step();
    count_np(3'd7, n);
    chk("R12 hold length", n, STAB);
    chk("R12 long hold reaches reset", n_state, 2);
    step(2); n_ext_rst = 0; step();
    chk("R3 nopor run", n_state, 3);
    n_stp_wr = 1; step(); n_stp_wr = 0; step();
    chk("R7 nopor stop", n_state, 5);
    n_ext_rst = 1; step(3); n_ext_rst = 0; step();
    chk("R12 short pulse back to stop", n_state, 5);
    n_ext_rst = 1; step();
    count_np(3'd7, n);
    chk("R12 long hold from stop", n_state, 2);
    n_ext_rst = 0; step();
    chk("R12 run after stop reset", n_state, 3);
  endtask

  initial begin
    pwr_up_n = 0; ext_rst = 0; int_rst = '0; slp_wr = 0; stp_wr = 0;
    irq = 0; ext_irq = 0;
    n_pwr_up_n = 0; n_ext_rst = 0; n_stp_wr = 0;
    t_powerup();
    t_sleep();
    t_stop();
    t_both_and_resets();
    t_nopor();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule